// File: doc/BRIEF.md
# Windowed load/store issue queue

This block holds memory operations in program order in a circular queue and chooses which of them may go to the memory pipeline. An operation is written at the tail when it is dispatched. It becomes ready when its operands arrive, which the core signals by the entry's tag. Ordinary queues let any ready entry issue. Here an entry may issue only if it lies inside a fixed-size window that begins at a virtual head. The virtual head is the oldest entry that has not issued yet. The window moves forward only when the entry at the virtual head issues. This limits how far memory operations can be reordered, which cuts down on ordering replays and on scattered cache accesses.

Allocation and issue are valid/ready streams. An allocation is taken on a cycle in which `alloc_valid` and `alloc_ready` are both high. `alloc_ready` drops while the queue is full and during a flush. The issue port offers the oldest eligible entry by holding `iss_valid` high. A transfer happens only on a cycle in which `iss_ready` is also high. While the consumer stalls, nothing in the queue changes because of the issue port. The offered tag may still change to an older entry that became ready in the meantime. Wake-up, retire and flush are plain control pins. Retirement removes the oldest entry once it has issued. A flush cuts the queue back to a given age.

The window size is the parameter `WIN`. A value of 0, or any value at least `DEPTH`, means no limit. A value of 1 forces strict program order. Every position handed out on `alloc_ptr` carries one wrap bit above the index, and a flush takes a position in that same form.

Top module: `memwin_issue_q`

## Requirements
- R1: After reset the queue reports empty (`q_empty`=1, `q_full`=0), `iss_valid`=0 and `alloc_ready`=1.
- R2: An allocation is accepted only when `alloc_valid` and `alloc_ready` are both high. `alloc_ptr` shows the position the next allocation will take: bits [AW-1:0] are the entry index and bit AW is the wrap bit. It grows by one for each accepted allocation. `alloc_ready` is 0 while the queue is full or `flush_en` is high.
- R3: `q_full` is 1 when DEPTH entries are occupied, and `q_empty` is 1 when none are.
- R4: `wake_en` with `wake_tag` marks the occupied, not-yet-ready entry with that index as ready. The entry becomes eligible from the following cycle.
- R5: A ready entry is eligible only if its distance from the virtual head is smaller than both WIN and the number of occupied entries from the virtual head to the tail.
- R6: Among eligible entries, `iss_valid`/`iss_tag`/`iss_data` present the one closest to the virtual head, that is, the oldest.
- R7: A transfer on the issue port marks the offered entry issued. With `iss_ready` low, the offer stays the same unless an older entry becomes ready.
- R8: The virtual head moves only when the entry at the virtual head issues. It then skips every already-issued entry that follows and stops at the first unissued entry or at the tail. Issuing any other entry leaves the window where it is.
- R9: With WIN=0 every ready occupied entry is eligible, and the oldest one is offered.
- R10: With WIN=1 only the entry at the virtual head can issue, so issue follows program order.
- R11: `retire_en` frees the entry at the head only if the queue is not empty and that entry has issued. In every other case it is ignored.
- R12: `flush_en` sets the tail to `flush_ptr` and pulls the virtual head back to `flush_ptr` if the virtual head was younger. During that cycle the queue blocks allocation, issue and retirement. `flush_ptr` must lie between head and tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Queue can accept an allocation |
| alloc_data | input | DW | Payload stored with the new entry |
| alloc_ptr | output | AW+1 | Position of the next allocation, with wrap bit |
| wake_en | input | 1 | Mark an entry ready |
| wake_tag | input | AW | Index of the entry to mark ready |
| iss_valid | output | 1 | An eligible entry is offered |
| iss_ready | input | 1 | Consumer takes the offered entry |
| iss_tag | output | AW | Index of the offered entry |
| iss_data | output | DW | Payload of the offered entry |
| retire_en | input | 1 | Free the head entry if it has issued |
| flush_en | input | 1 | Cut the queue back to `flush_ptr` |
| flush_ptr | input | AW+1 | New tail position, with wrap bit |
| q_full | output | 1 | All entries occupied |
| q_empty | output | 1 | No entry occupied |

## Verification
The assertions check several properties on every cycle:
- Occupancy never exceeds the depth.
- The virtual head stays between head and tail.
- An offered entry is ready and lies inside the window.
- Issuing a non-head entry leaves the window still, and issuing the head entry moves it.
- The real head advances by at most one per cycle.
- A full queue refuses allocation.

Some behaviours only the directed scenarios can show: which entry wins among several eligible ones, how far the window skips over entries that already issued, the window variants of size 1 and unlimited side by side, retirement being refused for an unissued head, and the virtual head being pulled back by a flush below it.

// File: rtl/mwq_pkg.sv
package mwq_pkg;

  // Per-entry lifecycle: waiting for operands, ready to issue, issued.
  typedef enum logic [1:0] {
    ENT_WAIT = 2'd0,
    ENT_RDY  = 2'd1,
    ENT_DONE = 2'd2
  } ent_st_e;

  // A window of 0 or at least the depth behaves as an unlimited window.
  function automatic int unsigned eff_window(int unsigned win, int unsigned depth);
    if (win == 0 || win >= depth) return depth;
    return win;
  endfunction

endpackage

// File: rtl/mwq_rotr.sv
// Rotates a vector so that bit k of the output is bit (base + k) mod N of the input.
module mwq_rotr #(
  parameter int SW = 4,
  localparam int N = 1 << SW
) (
  input  logic [N-1:0]  vec,
  input  logic [SW-1:0] base,
  output logic [N-1:0]  rot
);

  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam logic [SW-1:0] KOFF = SW'(k);
    logic [SW-1:0] src;
    assign src    = base + KOFF;
    assign rot[k] = vec[src];
  end

endmodule

// File: rtl/mwq_first.sv
// Finds the lowest set bit of a vector.
module mwq_first #(
  parameter int SW = 4,
  localparam int N = 1 << SW
) (
  input  logic [N-1:0]  vec,
  output logic [SW-1:0] pos,
  output logic          found
);

  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        pos   = SW'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/memwin_issue_q.sv
module memwin_issue_q
  import mwq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int unsigned WIN = 4,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [DW-1:0] alloc_data,
  output logic [PW-1:0] alloc_ptr,
  input  logic          wake_en,
  input  logic [AW-1:0] wake_tag,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [AW-1:0] iss_tag,
  output logic [DW-1:0] iss_data,
  input  logic          retire_en,
  input  logic          flush_en,
  input  logic [PW-1:0] flush_ptr,
  output logic          q_full,
  output logic          q_empty
);

  localparam int unsigned   WEFF    = eff_window(WIN, DEPTH);
  localparam logic [PW-1:0] WEFF_P  = PW'(WEFF);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  // Pointers: real head, tail, virtual head (all carry a wrap bit)
  logic [PW-1:0] head_q, tail_q, vh_q;
  logic [PW-1:0] head_d, tail_d, vh_d;
  logic [AW-1:0] head_i, tail_i, vh_i;

  ent_st_e       st_q  [DEPTH];
  logic [DW-1:0] pay_q [DEPTH];

  assign head_i = head_q[AW-1:0];
  assign tail_i = tail_q[AW-1:0];
  assign vh_i   = vh_q[AW-1:0];

  // Occupancy
  logic [PW-1:0] occ_all, occ_v, win_cnt;
  assign occ_all = tail_q - head_q;
  assign occ_v   = tail_q - vh_q;
  assign win_cnt = (occ_v > WEFF_P) ? WEFF_P : occ_v;
  assign q_empty = (occ_all == '0);
  assign q_full  = (occ_all == DEPTH_P);

  // Allocation stream
  logic alloc_fire;
  assign alloc_ready = !q_full && !flush_en;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_ptr   = tail_q;

  // Select: ready entries, seen from the virtual head, clipped to the window
  logic [DEPTH-1:0] rdy_vec, rdy_rot, rdy_win;
  logic [AW-1:0]    sel_off;
  logic             sel_found;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rdy
    assign rdy_vec[i] = (st_q[i] == ENT_RDY);
  end

  mwq_rotr #(.SW(AW)) u_rot_rdy (.vec(rdy_vec), .base(vh_i), .rot(rdy_rot));

  for (genvar k = 0; k < DEPTH; k++) begin : g_win
    localparam logic [PW-1:0] KP = PW'(k);
    assign rdy_win[k] = rdy_rot[k] && (KP < win_cnt);
  end

  mwq_first #(.SW(AW)) u_pick (.vec(rdy_win), .pos(sel_off), .found(sel_found));

  logic iss_fire;
  assign iss_valid = sel_found && !flush_en;
  assign iss_tag   = vh_i + sel_off;
  assign iss_data  = pay_q[iss_tag];
  assign iss_fire  = iss_valid && iss_ready;

  // Virtual head advance: skip the leading run of issued entries, stop at tail
  logic [DEPTH-1:0] done_nxt, done_rot;
  logic [AW-1:0]    und_off;
  logic             und_found;
  logic [PW-1:0]    adv, adv_c, vh_adv, age_vh, age_fl;

  for (genvar i = 0; i < DEPTH; i++) begin : g_done
    localparam logic [AW-1:0] IDX = AW'(i);
    assign done_nxt[i] = (st_q[i] == ENT_DONE) || (iss_fire && iss_tag == IDX);
  end

  mwq_rotr #(.SW(AW)) u_rot_done (.vec(done_nxt), .base(vh_i), .rot(done_rot));
  mwq_first #(.SW(AW)) u_scan (.vec(~done_rot), .pos(und_off), .found(und_found));

  assign adv    = und_found ? {1'b0, und_off} : DEPTH_P;
  assign adv_c  = (adv > occ_v) ? occ_v : adv;
  assign vh_adv = vh_q + adv_c;
  assign age_vh = vh_adv - head_q;
  assign age_fl = flush_ptr - head_q;
  assign vh_d   = (flush_en && age_vh > age_fl) ? flush_ptr : vh_adv;

  // Retire and tail
  logic ret_fire;
  assign ret_fire = retire_en && !flush_en && !q_empty && (st_q[head_i] == ENT_DONE);
  assign head_d   = head_q + PW'(ret_fire);
  assign tail_d   = flush_en ? flush_ptr : tail_q + PW'(alloc_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      vh_q   <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      vh_q   <= vh_d;
    end
  end

  // Per-entry state and payload
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [AW-1:0] IDX = AW'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st_q[i] <= ENT_WAIT;
      else if (alloc_fire && tail_i == IDX)
        st_q[i] <= ENT_WAIT;
      else if (iss_fire && iss_tag == IDX)
        st_q[i] <= ENT_DONE;
      else if (wake_en && wake_tag == IDX && st_q[i] == ENT_WAIT)
        st_q[i] <= ENT_RDY;
    end

    always_ff @(posedge clk) begin
      if (alloc_fire && tail_i == IDX) pay_q[i] <= alloc_data;
    end
  end

  // ---------------- assertions ----------------
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= DEPTH_P);

  // R8
  vh_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vh_q - head_q) <= (tail_q - head_q));

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !alloc_ready);

  // R5
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ({1'b0, AW'(iss_tag - vh_i)} < WEFF_P) && ({1'b0, AW'(iss_tag - vh_i)} < occ_v));

  // R7
  issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (st_q[iss_tag] == ENT_RDY));

  // R8
  slide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && iss_tag != vh_i) |=> $stable(vh_q));

  // R8
  slide_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && iss_tag == vh_i) |=> (vh_q != $past(vh_q)));

  // R11
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_en |=> ((head_q - $past(head_q)) <= PW'(1)));

endmodule

// File: tb/sim_memwin_issue_q.sv
module sim_memwin_issue_q;

  localparam int DEPTH = 16;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          alloc_valid = 0;
  logic [DW-1:0] alloc_data = '0;
  logic          wake_en = 0;
  logic [AW-1:0] wake_tag = '0;
  logic          retire_en = 0;
  logic          flush_en = 0;
  logic [PW-1:0] flush_ptr = '0;
  logic          rdy0 = 0, rdy1 = 0, rdy2 = 0;

  logic          a_rdy0, a_rdy1, a_rdy2;
  logic [PW-1:0] a_ptr0, a_ptr1, a_ptr2;
  logic          v0, v1, v2;
  logic [AW-1:0] t0, t1, t2;
  logic [DW-1:0] d0, d1, d2;
  logic          f0, f1, f2, e0, e1, e2;

  memwin_issue_q #(.DEPTH(DEPTH), .WIN(4), .DW(DW)) u0 (
    .clk, .rst_n, .alloc_valid, .alloc_ready(a_rdy0), .alloc_data, .alloc_ptr(a_ptr0),
    .wake_en, .wake_tag, .iss_valid(v0), .iss_ready(rdy0), .iss_tag(t0), .iss_data(d0),
    .retire_en, .flush_en, .flush_ptr, .q_full(f0), .q_empty(e0));

  memwin_issue_q #(.DEPTH(DEPTH), .WIN(1), .DW(DW)) u1 (
    .clk, .rst_n, .alloc_valid, .alloc_ready(a_rdy1), .alloc_data, .alloc_ptr(a_ptr1),
    .wake_en, .wake_tag, .iss_valid(v1), .iss_ready(rdy1), .iss_tag(t1), .iss_data(d1),
    .retire_en, .flush_en, .flush_ptr, .q_full(f1), .q_empty(e1));

  memwin_issue_q #(.DEPTH(DEPTH), .WIN(0), .DW(DW)) u2 (
    .clk, .rst_n, .alloc_valid, .alloc_ready(a_rdy2), .alloc_data, .alloc_ptr(a_ptr2),
    .wake_en, .wake_tag, .iss_valid(v2), .iss_ready(rdy2), .iss_tag(t2), .iss_data(d2),
    .retire_en, .flush_en, .flush_ptr, .q_full(f2), .q_empty(e2));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    alloc_valid = 0; wake_en = 0; retire_en = 0; flush_en = 0;
    rdy0 = 0; rdy1 = 0; rdy2 = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic do_alloc(int n, int base);
    for (int i = 0; i < n; i++) begin
      alloc_valid = 1;
      alloc_data  = DW'(base + i);
      tick();
    end
    alloc_valid = 0;
  endtask

  task automatic do_wake(int tag);
    wake_en  = 1;
    wake_tag = AW'(tag);
    tick();
    wake_en = 0;
  endtask

  task automatic issue0(string req, int exp_tag);
    chk({req, " offer valid"}, int'(v0), 1);
    chk({req, " offer tag"}, int'(t0), exp_tag);
    rdy0 = 1;
    tick();
    rdy0 = 0;
  endtask

  task automatic sc_reset();
    do_reset();
    chk("R1 empty", int'(e0), 1);
    chk("R1 full", int'(f0), 0);
    chk("R1 iss_valid", int'(v0), 0);
    chk("R1 alloc_ready", int'(a_rdy0), 1);
  endtask

  task automatic sc_window();
    do_reset();
    do_alloc(8, 'h40);
    chk("R2 alloc_ptr after 8", int'(a_ptr0), 8);
    chk("R3 not empty", int'(e0), 0);
    do_wake(5);
    chk("R5 entry 5 outside window", int'(v0), 0);
    chk("R10 strict order blocks 5", int'(v1), 0);
    chk("R9 unlimited valid", int'(v2), 1);
    chk("R9 unlimited tag", int'(t2), 5);
    do_wake(2);
    chk("R4 R5 woken entry in window", int'(v0), 1);
    chk("R5 tag", int'(t0), 2);
    chk("R5 data", int'(d0), 'h42);
    chk("R10 strict order blocks 2", int'(v1), 0);
    chk("R6 unlimited oldest", int'(t2), 2);
    tick();
    chk("R7 offer held valid", int'(v0), 1);
    chk("R7 offer held tag", int'(t0), 2);
    do_wake(0);
    chk("R6 oldest wins", int'(t0), 0);
    chk("R10 head offered", int'(v1), 1);
    chk("R10 head tag", int'(t1), 0);
    chk("R9 oldest tag", int'(t2), 0);
  endtask

  task automatic sc_slide();
    do_reset();
    do_alloc(8, 'h50);
    do_wake(0); do_wake(2); do_wake(5);
    issue0("R6 head first", 0);
    chk("R8 window at 1 offers 2", int'(t0), 2);
    issue0("R7 non-head issue", 2);
    chk("R8 window held, 5 not eligible", int'(v0), 0);
    do_wake(1);
    issue0("R8 head entry 1", 1);
    chk("R8 skip to 3, 5 eligible", int'(v0), 1);
    chk("R8 skip tag", int'(t0), 5);
    chk("R8 skip data", int'(d0), 'h55);
  endtask

  task automatic sc_full_retire();
    do_reset();
    do_alloc(16, 'h10);
    chk("R3 full", int'(f0), 1);
    chk("R2 blocked when full", int'(a_rdy0), 0);
    alloc_valid = 1; alloc_data = 'hEE;
    tick();
    alloc_valid = 0;
    chk("R2 refused alloc ptr", int'(a_ptr0), 16);
    retire_en = 1;
    tick();
    retire_en = 0;
    chk("R11 unissued head kept", int'(f0), 1);
    do_wake(0);
    issue0("R11 prep", 0);
    retire_en = 1;
    tick();
    retire_en = 0;
    chk("R11 issued head freed", int'(f0), 0);
    do_alloc(1, 'h99);
    chk("R2 wrapped ptr", int'(a_ptr0), 17);
    chk("R3 full again", int'(f0), 1);
  endtask

  task automatic sc_flush();
    do_reset();
    do_alloc(6, 'h60);
    do_wake(0); do_wake(1);
    issue0("R12 prep 0", 0);
    issue0("R12 prep 1", 1);
    do_wake(4);
    chk("R12 entry 4 offered", int'(t0), 4);
    flush_en = 1; flush_ptr = PW'(3);
    #1;
    chk("R12 issue blocked", int'(v0), 0);
    chk("R12 alloc blocked", int'(a_rdy0), 0);
    tick();
    flush_en = 0;
    chk("R12 flushed entry gone", int'(v0), 0);
    chk("R12 tail moved", int'(a_ptr0), 3);
    flush_en = 1; flush_ptr = PW'(1);
    tick();
    flush_en = 0;
    chk("R12 tail at 1", int'(a_ptr0), 1);
    do_alloc(1, 'h77);
    do_wake(1);
    chk("R12 vhead clamped valid", int'(v0), 1);
    chk("R12 vhead clamped tag", int'(t0), 1);
    chk("R12 vhead clamped data", int'(d0), 'h77);
    chk("R3 not empty", int'(e0), 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    sc_reset();
    sc_window();
    sc_slide();
    sc_full_retire();
    sc_flush();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule